// File: doc/BRIEF.md
# Flash Program Memory Controller

This block models the programming side of a byte-programmed on-chip code store. A parallel programming port presents an address, a data byte and a 3-bit mode code. An active-low programme strobe starts each operation. A falling strobe in a programming mode launches a self-timed operation. The operation is either a byte write or the setting of one of three protection bits. The block reports its progress on a ready output, and once started it needs no further handshake. The array is a register array. The write time is counted in clock cycles.

Holding the strobe low in the erase mode for long enough clears the whole array to 0xFF and removes all protection bits. The array can only clear bits, so writing over a byte that is not blank stores the AND of the old and new values. Verify reads return stored data unless protection bit 1 or 2 is set. While a byte write is running, a read at the address being written shows the pending value with its top bit inverted. A separate mode returns fixed identification bytes.

Top module: `fpm_ctrl`

## Requirements
- R1: After reset and after an erase, a verify read at every address returns 0xFF.
- R2: In byte-write mode (mode 1), a falling strobe seen while ready starts a write of din to addr. The write commits after exactly WRITE_CYC cycles, and later verify reads return the new value.
- R3: While a write is pending, a verify read (mode 2) at the written address returns the pending value with bit 7 inverted and bits 6..0 true. Reads at other addresses return their stored data. After completion the true value is returned.
- R4: ready is high after reset. It is low from the cycle after the starting strobe edge until the operation commits.
- R5: In erase mode (mode 3), holding strobe low for ERASE_CYC consecutive cycles while ready erases the array to 0xFF and clears all three protection bits. A shorter hold changes nothing.
- R6: Writing over a programmed byte stores the bitwise AND of the old and new values.
- R7: In signature mode (mode 4), address 0x030 returns 0x1E and 0x031 returns 0x51. Address 0x032 returns 0xFF when HIGH_VOLT is 1 and 0x05 when it is 0. Other addresses return 0x00. Protection bits do not affect this mode.
- R8: Modes 5, 6 and 7 set protection bits 1, 2 and 3, using the same timed sequence as a byte write. Once bit 1 or bit 2 is set, verify reads return 0xFF. Bit 3 alone does not change reads, and no port shows the bits directly.
- R9: Strobe edges that arrive while busy start nothing and alter no byte.
- R10: In idle (mode 0), write, erase and protection modes, dout is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operation code (0 idle, 1 write, 2 verify, 3 erase, 4 signature, 5..7 protection bit 1..3) |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to program |
| strobe_n | input | 1 | Active-low programme strobe |
| dout | output | 8 | Read data, combinational from mode and addr |
| ready | output | 1 | High when no timed operation is running |

## Verification
The properties assume that mode, addr and din are valid on the clock edge where the strobe is first seen low. They also assume that mode stays at the erase code for the whole of an erase hold. The bench changes inputs only on falling clock edges, so every input is steady at each rising edge. Erase holds keep mode fixed from the falling strobe to its release. The bench also pulses the strobe during a running write to confirm that such pulses do nothing.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  localparam int LOCKS = 3;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_WRITE = 3'd1,
    M_READ  = 3'd2,
    M_ERASE = 3'd3,
    M_SIG   = 3'd4,
    M_LOCK1 = 3'd5,
    M_LOCK2 = 3'd6,
    M_LOCK3 = 3'd7
  } fpm_mode_e;

  // cells only clear bits: a rewrite keeps the AND of old and new
  function automatic logic [7:0] merge_byte(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  // value presented while a write is still running
  function automatic logic [7:0] poll_byte(input logic [7:0] target);
    return {~target[7], target[6:0]};
  endfunction

  function automatic logic [7:0] sig_byte(input logic [15:0] a, input logic hv);
    case (a)
      16'h0030: return 8'h1E;
      16'h0031: return 8'h51;
      16'h0032: return hv ? 8'hFF : 8'h05;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic is_prog_mode(input fpm_mode_e m);
    return (m == M_WRITE) || (m == M_LOCK1) || (m == M_LOCK2) || (m == M_LOCK3);
  endfunction

  function automatic logic [LOCKS-1:0] lock_onehot(input fpm_mode_e m);
    case (m)
      M_LOCK1: return 3'b001;
      M_LOCK2: return 3'b010;
      M_LOCK3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/fpm_array.sv
module fpm_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int NLOCK  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NLOCK-1:0]  lock_set,
  input  logic              erase,
  output logic [NLOCK-1:0]  locks
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      locks <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      locks <= locks | lock_set;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fpm_prog_seq.sv
module fpm_prog_seq
  import fpm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpm_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              strobe_n,
  input  logic [7:0]        cur_byte,
  output logic              busy,
  output logic              start,
  output logic              commit,
  output logic              wr_en,
  output logic [ADDR_W-1:0] w_addr,
  output logic [7:0]        w_data,
  output logic [LOCKS-1:0]  lock_set,
  output logic              poll_hit
);
  localparam int CNT_W = $clog2(WRITE_CYC + 1);

  logic             strobe_q;
  logic [CNT_W-1:0] cnt;
  logic             kind_byte;
  logic [LOCKS-1:0] lock_sel;
  logic             fall;

  assign fall   = strobe_q & ~strobe_n;
  assign start  = ~busy & fall & is_prog_mode(mode);
  assign commit = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b1;
      busy      <= 1'b0;
      cnt       <= '0;
      kind_byte <= 1'b0;
      lock_sel  <= '0;
      w_addr    <= '0;
      w_data    <= '1;
    end else begin
      strobe_q <= strobe_n;
      if (start) begin
        busy      <= 1'b1;
        cnt       <= CNT_W'(WRITE_CYC - 1);
        w_addr    <= addr;
        w_data    <= merge_byte(cur_byte, din);
        kind_byte <= (mode == M_WRITE);
        lock_sel  <= lock_onehot(mode);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign wr_en    = commit & kind_byte;
  assign lock_set = (commit & ~kind_byte) ? lock_sel : '0;
  assign poll_hit = busy & kind_byte & (addr == w_addr);
endmodule

// File: rtl/fpm_erase_timer.sv
module fpm_erase_timer #(
  parameter int ERASE_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);
  localparam int HW = $clog2(ERASE_CYC + 1);
  localparam logic [HW-1:0] LIM = HW'(ERASE_CYC - 1);

  logic [HW-1:0] hcnt;
  logic          done;

  assign fire = arm & ~done & (hcnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      hcnt <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (hcnt == LIM) done <= 1'b1;
      else             hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/fpm_rdmux.sv
module fpm_rdmux
  import fpm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  fpm_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_byte,
  input  logic              poll_hit,
  input  logic [7:0]        pend_byte,
  input  logic              read_block,
  output logic [7:0]        dout
);
  always_comb begin
    case (mode)
      M_SIG:  dout = sig_byte(16'(addr), HIGH_VOLT);
      M_READ: begin
        if (poll_hit)        dout = poll_byte(pend_byte);
        else if (read_block) dout = 8'hFF;
        else                 dout = arr_byte;
      end
      default: dout = 8'hFF;
    endcase
  end
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 24,
  parameter int ERASE_CYC = 40,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              strobe_n,
  output logic [7:0]        dout,
  output logic              ready
);
  fpm_mode_e         mode_e;
  logic [7:0]        arr_byte;
  logic              busy, wr_start, wr_commit, wr_en, poll_hit;
  logic [ADDR_W-1:0] w_addr;
  logic [7:0]        w_data;
  logic [LOCKS-1:0]  lock_set, locks;
  logic              erase_arm, erase_fire, read_block;

  assign mode_e     = fpm_mode_e'(mode);
  assign ready      = ~busy;
  assign erase_arm  = ~busy & (mode_e == M_ERASE) & ~strobe_n;
  assign read_block = locks[0] | locks[1];

  fpm_array #(.ADDR_W(ADDR_W), .DATA_W(8), .NLOCK(LOCKS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(addr), .rd_data(arr_byte),
    .wr_en(wr_en), .wr_addr(w_addr), .wr_data(w_data),
    .lock_set(lock_set), .erase(erase_fire), .locks(locks)
  );

  fpm_prog_seq #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .addr(addr), .din(din),
    .strobe_n(strobe_n), .cur_byte(arr_byte),
    .busy(busy), .start(wr_start), .commit(wr_commit), .wr_en(wr_en),
    .w_addr(w_addr), .w_data(w_data), .lock_set(lock_set), .poll_hit(poll_hit)
  );

  fpm_erase_timer #(.ERASE_CYC(ERASE_CYC)) u_erase (
    .clk(clk), .rst_n(rst_n), .arm(erase_arm), .fire(erase_fire)
  );

  fpm_rdmux #(.ADDR_W(ADDR_W), .HIGH_VOLT(HIGH_VOLT)) u_rd (
    .mode(mode_e), .addr(addr), .arr_byte(arr_byte), .poll_hit(poll_hit),
    .pend_byte(w_data), .read_block(read_block), .dout(dout)
  );
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic              strobe_n,
  input logic [7:0]        dout,
  input logic              ready,
  input logic              wr_start,
  input logic              wr_commit,
  input logic              busy,
  input logic              erase_fire,
  input logic [7:0]        arr_byte
);
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        bcnt <= 0;
    else if (wr_start) bcnt <= 0;
    else if (busy)     bcnt <= bcnt + 1;
  end

  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !ready);
  p_ready_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> ready);
  p_write_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (bcnt == WRITE_CYC - 1));
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_start);
  p_erase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |-> (!strobe_n && mode == 3'd3 && ready));
  p_erase_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> (arr_byte == 8'hFF));
  p_sig_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && addr == ADDR_W'(48)) |-> (dout == 8'h1E));
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (dout == 8'hFF));
endmodule

bind fpm_ctrl fpm_ctrl_chk #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .strobe_n(strobe_n),
  .dout(dout), .ready(ready), .wr_start(wr_start), .wr_commit(wr_commit),
  .busy(busy), .erase_fire(erase_fire), .arr_byte(arr_byte)
);

// File: tb/fpm_ctrl_test.sv
`timescale 1ns/1ps
module fpm_ctrl_test;
  localparam int WC = 24;
  localparam int EC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [11:0] addr = '0;
  logic [7:0]  din = '0;
  logic        strobe_n = 1'b1;
  logic [7:0]  dout;
  logic        ready;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  fpm_ctrl #(.ADDR_W(12), .WRITE_CYC(WC), .ERASE_CYC(EC), .HIGH_VOLT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(din),
    .strobe_n(strobe_n), .dout(dout), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [2:0] m, input logic [11:0] a,
                          input logic [7:0] exp);
    @(negedge clk); mode = m; addr = a; #1;
    chk(req, dout, exp);
  endtask

  // strobe once, then count negedges with ready low
  task automatic prog(input logic [2:0] m, input logic [11:0] a, input logic [7:0] d,
                      output int busy_n);
    @(negedge clk); mode = m; addr = a; din = d; strobe_n = 1'b0;
    @(negedge clk); strobe_n = 1'b1; busy_n = 0;
    while (!ready && busy_n < 4*WC) begin busy_n++; @(negedge clk); end
  endtask

  task automatic erase_hold(input int cyc);
    @(negedge clk); mode = 3'd3; strobe_n = 1'b0;
    repeat (cyc) @(negedge clk);
    strobe_n = 1'b1; mode = 3'd0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1 chk("R4 ready after reset", {7'b0, ready}, 8'h01);
    read_chk("R1 blank at 0x000", 3'd2, 12'h000, 8'hFF);
    read_chk("R1 blank at 0xFFF", 3'd2, 12'hFFF, 8'hFF);
    read_chk("R10 idle mode bus", 3'd0, 12'h123, 8'hFF);
    read_chk("R10 erase mode bus", 3'd3, 12'h123, 8'hFF);
  endtask

  task automatic t_write_poll(input logic [11:0] a, input logic [7:0] d, input logic [11:0] other);
    int n;
    @(negedge clk); mode = 3'd1; addr = a; din = d; strobe_n = 1'b0;
    @(negedge clk); strobe_n = 1'b1; mode = 3'd2; #1;
    chk("R4 ready low after start", {7'b0, ready}, 8'h00);
    chk("R3 poll inverted bit7", dout, {~d[7], d[6:0]});
    addr = other; #1;
    chk("R3 other address during write", dout, 8'hFF);
    addr = a;
    n = 1;
    forever begin
      @(negedge clk);
      if (ready || n > 4*WC) break;
      n++;
    end
    #1;
    chk("R2 busy length", 8'(n), 8'(WC));
    chk("R3 true data after write", dout, d);
  endtask

  task automatic t_rewrite;
    int n;
    prog(3'd1, 12'h300, 8'hF0, n);
    prog(3'd1, 12'h300, 8'h3F, n);
    read_chk("R6 AND of old and new", 3'd2, 12'h300, 8'h30);
    prog(3'd1, 12'h300, 8'hFF, n);
    read_chk("R6 all-ones rewrite keeps", 3'd2, 12'h300, 8'h30);
  endtask

  task automatic t_busy_ignore;
    int n;
    @(negedge clk); mode = 3'd1; addr = 12'h400; din = 8'h11; strobe_n = 1'b0;
    @(negedge clk); strobe_n = 1'b1;
    @(negedge clk); addr = 12'h401; din = 8'h00; strobe_n = 1'b0;
    @(negedge clk); strobe_n = 1'b1;
    n = 3;
    forever begin
      @(negedge clk);
      if (ready || n > 4*WC) break;
      n++;
    end
    chk("R9 busy not extended", 8'(n), 8'(WC));
    read_chk("R9 ignored strobe wrote nothing", 3'd2, 12'h401, 8'hFF);
    read_chk("R2 first write landed", 3'd2, 12'h400, 8'h11);
  endtask

  task automatic t_sig;
    read_chk("R7 signature 0x030", 3'd4, 12'h030, 8'h1E);
    read_chk("R7 signature 0x031", 3'd4, 12'h031, 8'h51);
    read_chk("R7 signature 0x032", 3'd4, 12'h032, 8'hFF);
    read_chk("R7 signature other", 3'd4, 12'h033, 8'h00);
  endtask

  task automatic t_locks_erase;
    int n;
    erase_hold(EC - 1);
    read_chk("R5 short hold keeps data", 3'd2, 12'h123, 8'h3C);
    prog(3'd7, 12'h000, 8'h00, n);
    chk("R8 protection write timing", 8'(n), 8'(WC));
    read_chk("R8 bit3 alone keeps reads", 3'd2, 12'h123, 8'h3C);
    prog(3'd5, 12'h000, 8'h00, n);
    read_chk("R8 bit1 blocks read", 3'd2, 12'h123, 8'hFF);
    read_chk("R8 bit1 blocks read 0x200", 3'd2, 12'h200, 8'hFF);
    read_chk("R7 signature while protected", 3'd4, 12'h031, 8'h51);
    erase_hold(EC);
    chk("R5 ready through erase", {7'b0, ready}, 8'h01);
    prog(3'd1, 12'h123, 8'h5A, n);
    read_chk("R5 erase cleared protection", 3'd2, 12'h123, 8'h5A);
    read_chk("R1 erased 0x300", 3'd2, 12'h300, 8'hFF);
    read_chk("R1 erased 0x200", 3'd2, 12'h200, 8'hFF);
    prog(3'd6, 12'h000, 8'h00, n);
    read_chk("R8 bit2 blocks read", 3'd2, 12'h123, 8'hFF);
    erase_hold(EC);
    read_chk("R1 erased after second erase", 3'd2, 12'h400, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_poll(12'h123, 8'h3C, 12'h124);
    t_write_poll(12'h200, 8'hA5, 12'h000);
    t_rewrite();
    t_busy_ignore();
    t_sig();
    t_locks_erase();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule